// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns a parallel byte into an asynchronous serial frame on a single output line. A five-bit format word sets the frame layout: 5 to 8 data bits, an optional parity bit (even or odd), and one or two stop bits. The word is captured into an internal format register only while a load strobe is high. Each frame opens with a low start bit, carries the data least significant bit first, adds parity if enabled, and closes with high stop bits. Between frames the line rests high.

Software-side logic writes a byte into a one-entry holding buffer. When the shift stage is idle, the byte moves into a 12-bit frame register on the next clock. The frame register then shifts right once every 16 pulses of an external baud-enable input. Two flags report on the pipeline. One shows that the holding buffer can take a new byte. The other shows that the shift stage has finished its last frame. The frame layout is fixed when a byte enters the shift stage, so a format change during a frame takes effect only from the next frame.

Top module: `uart_frame_tx`

## Requirements
- R1: The format register loads `fmt_word` on a clock edge where `fmt_load` is high and holds its value otherwise. Field positions: bits [1:0] select the data length, bit 2 turns parity off when 1, bit 3 selects even parity when 1 (odd when 0), and bit 4 selects two stop bits when 1. After reset the register holds 5'b00111 (8 data bits, no parity, 1 stop bit).
- R2: During and after reset, with no byte written, `txd` is 1 and both `hold_empty` and `shift_empty` are 1.
- R3: A frame goes out as follows: one start bit of 0, then the data bits least significant first, then the parity bit if enabled, then the stop bits of value 1. After the last stop bit the line returns to idle 1.
- R4: The length field selects the data bits sent: 2'b00 sends 5, 2'b01 sends 6, 2'b10 sends 7 and 2'b11 sends 8. Higher byte bits are not sent.
- R5: With parity enabled, the parity bit makes the count of ones over the sent data bits plus the parity bit even (even mode) or odd (odd mode). With parity off, no parity bit is sent.
- R6: A frame lasts (1 + data bits + parity bits + stop bits) × 16 baud ticks. `shift_empty` rises on the clock edge that ends the last stop bit.
- R7: Each bit stays on `txd` for 16 clock edges on which `baud_tick` is high. While `baud_tick` is low the line and the frame position do not advance.
- R8: A write (`wr_en` high) clears `hold_empty` on that edge. If the shift stage is idle, the byte enters it on the next edge. On that edge `hold_empty` returns to 1, `shift_empty` goes to 0 and `txd` shows the start bit.
- R9: A byte written while a frame is in progress stays in the holding buffer, with `hold_empty` low. It enters the shift stage on the edge after `shift_empty` rises.
- R10: The frame layout uses the format register value at the moment the byte enters the shift stage. A format load during a frame does not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_load | input | 1 | Format register load strobe |
| fmt_word | input | 5 | Format word (field layout in R1) |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to transmit |
| baud_tick | input | 1 | Baud enable, 16 pulses per bit |
| txd | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Holding buffer can take a byte |
| shift_empty | output | 1 | Shift stage idle, no frame in flight |

## Verification
A write clears `hold_empty` one edge after the strobe. The start bit, `hold_empty` returning high and `shift_empty` falling all appear on the following edge. With `baud_tick` held high, bit k of the frame occupies the 16 edges after load edge + 16k, and `shift_empty` rises exactly 16 × frame-length edges after the load edge. The bench drives inputs on falling edges. It counts falling edges from the load edge and samples every bit in the middle of its 16-cycle window. It checks `shift_empty` both one cycle before and on the cycle it is due to rise, so a wrong stop count or frame length is caught. A queued byte is checked to still be pending at the end of the first frame and to start exactly one edge later.

// File: rtl/uart_frame_tx_pkg.sv
package uart_frame_tx_pkg;

    localparam int DATA_W   = 8;
    localparam int FRAME_W  = 12;
    localparam int LEN_W    = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic       two_stop;
        logic       even_par;
        logic       par_off;
        logic [1:0] len_sel;
    } fmt_t;

    localparam fmt_t FMT_RESET = '{two_stop: 1'b0, even_par: 1'b0,
                                   par_off: 1'b1, len_sel: 2'b11};

    function automatic logic [3:0] data_count(input logic [1:0] len_sel);
        return 4'd5 + {2'b00, len_sel};
    endfunction

    function automatic logic [LEN_W-1:0] frame_bits(input fmt_t f);
        logic [LEN_W-1:0] n;
        n = LEN_W'(1) + LEN_W'(data_count(f.len_sel));
        if (!f.par_off) n = n + LEN_W'(1);
        n = n + (f.two_stop ? LEN_W'(2) : LEN_W'(1));
        return n;
    endfunction

    function automatic logic parity_of(input fmt_t f, input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] m;
        logic [3:0]        n;
        n = data_count(f.len_sel);
        for (int i = 0; i < DATA_W; i++) m[i] = (i < int'(n)) ? d[i] : 1'b0;
        return f.even_par ? ^m : ~^m;
    endfunction

    function automatic logic [FRAME_W-1:0] assemble(input fmt_t f, input logic [DATA_W-1:0] d);
        logic [FRAME_W-1:0] fr;
        logic [3:0]         n;
        n     = data_count(f.len_sel);
        fr    = '1;
        fr[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(n)) fr[i+1] = d[i];
        end
        if (!f.par_off) fr[n+1] = parity_of(f, d);
        return fr;
    endfunction

endpackage

// File: rtl/tx_fmt_reg.sv
module tx_fmt_reg
    import uart_frame_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [4:0] word,
    output fmt_t       fmt
);
    always_ff @(posedge clk) begin
        if (rst)       fmt <= FMT_RESET;
        else if (load) fmt <= fmt_t'(word);
    end
endmodule

// File: rtl/tx_hold_buf.sv
module tx_hold_buf
    import uart_frame_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] data,
    output logic              full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            full <= 1'b0;
        end else begin
            if (wr_en) begin
                data <= wr_data;
                full <= 1'b1;
            end else if (take) begin
                full <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import uart_frame_tx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               baud_tick,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [LEN_W-1:0]   len_in,
    output logic               txd,
    output logic               busy
);
    localparam int TW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [TW-1:0] TLAST = TW'(OVERSAMPLE - 1);

    logic [FRAME_W-1:0] frame_q;
    logic [LEN_W-1:0]   left_q;
    logic [TW-1:0]      tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '1;
            left_q  <= '0;
            tick_q  <= '0;
            busy    <= 1'b0;
        end else if (load) begin
            frame_q <= frame_in;
            left_q  <= len_in;
            tick_q  <= '0;
            busy    <= 1'b1;
        end else if (busy && baud_tick) begin
            if (tick_q == TLAST) begin
                tick_q  <= '0;
                frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
                left_q  <= left_q - LEN_W'(1);
                if (left_q == LEN_W'(1)) busy <= 1'b0;
            end else begin
                tick_q <= tick_q + TW'(1);
            end
        end
    end

    assign txd = busy ? frame_q[0] : 1'b1;
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_frame_tx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fmt_load,
    input  logic [4:0] fmt_word,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       baud_tick,
    output logic       txd,
    output logic       hold_empty,
    output logic       shift_empty
);
    fmt_t               fmt;
    logic [4:0]         fmt_bits;
    logic [DATA_W-1:0]  hold_data;
    logic               hold_full;
    logic               busy;
    logic               take;
    logic [FRAME_W-1:0] frame_next;
    logic [LEN_W-1:0]   len_next;

    tx_fmt_reg u_fmt (
        .clk (clk), .rst (rst), .load (fmt_load), .word (fmt_word), .fmt (fmt)
    );

    tx_hold_buf u_hold (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_data (wr_data),
        .take (take), .data (hold_data), .full (hold_full)
    );

    always_comb begin
        take       = hold_full && !busy;
        frame_next = assemble(fmt, hold_data);
        len_next   = frame_bits(fmt);
        fmt_bits   = fmt;
    end

    tx_shifter #(.OVERSAMPLE(OVERSAMPLE)) u_shift (
        .clk (clk), .rst (rst), .baud_tick (baud_tick), .load (take),
        .frame_in (frame_next), .len_in (len_next), .txd (txd), .busy (busy)
    );

    assign hold_empty  = !hold_full;
    assign shift_empty = !busy;
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
    input logic       clk,
    input logic       rst,
    input logic       fmt_load,
    input logic [4:0] fmt_word,
    input logic [4:0] fmt_q,
    input logic       wr_en,
    input logic       baud_tick,
    input logic       txd,
    input logic       hold_empty,
    input logic       shift_empty
);
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        shift_empty |-> txd);                                            // R2
    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(shift_empty) |-> !txd);                                    // R3
    AST_FMT_KEEP: assert property (@(posedge clk) disable iff (rst)
        !fmt_load |=> $stable(fmt_q));                                   // R1
    AST_FMT_TAKE: assert property (@(posedge clk) disable iff (rst)
        fmt_load |=> fmt_q == $past(fmt_word));                          // R1
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !hold_empty);                                          // R8
    AST_NO_TICK_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!baud_tick && !shift_empty && !wr_en) |=> $stable(txd) && !shift_empty); // R7
    AST_ENDS_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(shift_empty) |-> $past(txd));                              // R6
    AST_QUEUE_WAITS: assert property (@(posedge clk) disable iff (rst)
        (!hold_empty && !shift_empty && !wr_en) |=> !hold_empty);        // R9
endmodule

bind uart_frame_tx uart_frame_tx_chk u_chk (
    .clk (clk), .rst (rst), .fmt_load (fmt_load), .fmt_word (fmt_word),
    .fmt_q (fmt_bits), .wr_en (wr_en), .baud_tick (baud_tick), .txd (txd),
    .hold_empty (hold_empty), .shift_empty (shift_empty)
);

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       fmt_load;
    logic [4:0] fmt_word;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       baud_tick;
    logic       txd;
    logic       hold_empty;
    logic       shift_empty;

    always #2 clk = ~clk;

    uart_frame_tx uut (
        .clk (clk), .rst (rst), .fmt_load (fmt_load), .fmt_word (fmt_word),
        .wr_en (wr_en), .wr_data (wr_data), .baud_tick (baud_tick), .txd (txd),
        .hold_empty (hold_empty), .shift_empty (shift_empty)
    );

    int         n_cmp = 0;
    int         n_bad = 0;
    bit         finished = 0;
    logic [4:0] cur_fmt;

    // {format(5), byte(8)}; format = {two_stop, even, par_off, len[1:0]}
    localparam logic [12:0] VEC [8] = '{
        {5'b00111, 8'hA5},   // 8 data, none, 1 stop
        {5'b11011, 8'h3C},   // 8 data, even, 2 stop (12-bit frame)
        {5'b00000, 8'h1F},   // 5 data, odd, 1 stop
        {5'b01001, 8'hF2},   // 6 data, even, 1 stop
        {5'b10110, 8'h55},   // 7 data, none, 2 stop
        {5'b10100, 8'hFF},   // 5 data, none, 2 stop
        {5'b00010, 8'h00},   // 7 data, odd, 1 stop
        {5'b11000, 8'hE7}    // 5 data, even, 2 stop
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected line bits, index 0 first on the wire; returns bit count.
    function automatic int expect_bits(input logic [4:0] f, input logic [7:0] d,
                                       output logic [11:0] bits);
        int nd, pos, ones;
        nd   = 5 + int'(f[1:0]);
        bits = '1;
        pos  = 0;
        bits[pos] = 1'b0; pos++;
        ones = 0;
        for (int i = 0; i < nd; i++) begin
            bits[pos] = d[i]; pos++;
            if (d[i]) ones++;
        end
        if (!f[2]) begin
            bits[pos] = f[3] ? ((ones % 2) == 1) : ((ones % 2) == 0);
            pos++;
        end
        pos += f[4] ? 2 : 1;
        return pos;
    endfunction

    task automatic set_fmt(input logic [4:0] w);
        @(negedge clk); fmt_word = w; fmt_load = 1'b1;
        @(negedge clk); fmt_load = 1'b0;
        cur_fmt = w;
    endtask

    // Called on the falling edge right after the load edge.
    task automatic drain(input logic [11:0] ex, input int n, input string req,
                         input bit mid_change, input logic [4:0] new_fmt);
        logic [11:0] got, mask;
        got  = '1;
        mask = '0;
        for (int i = 0; i < n; i++) begin
            mask[i] = 1'b1;
            if (mid_change && i == 1) begin
                set_fmt(new_fmt);
                repeat (6) @(negedge clk);
            end else begin
                repeat (8) @(negedge clk);
            end
            got[i] = txd;
            if (i == n - 1) begin
                repeat (7) @(negedge clk);
                check(shift_empty == 1'b0, "R6", "busy before last edge", shift_empty, 0);
                @(negedge clk);
            end else begin
                repeat (8) @(negedge clk);
            end
        end
        check((got & mask) == (ex & mask), req, "frame bits", got & mask, ex & mask);
        check(shift_empty == 1'b1 && txd == 1'b1, "R6", "idle after frame",
              {shift_empty, txd}, 2'b11);
    endtask

    task automatic send(input logic [7:0] d, input string req,
                        input bit mid_change, input logic [4:0] new_fmt);
        logic [11:0] ex;
        int          n;
        n = expect_bits(cur_fmt, d, ex);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
        check(hold_empty == 1'b0, "R8", "hold_empty after write", hold_empty, 0);
        @(negedge clk);
        check(hold_empty == 1'b1 && shift_empty == 1'b0 && txd == 1'b0, "R8",
              "load into shifter", {hold_empty, shift_empty, txd}, 3'b100);
        drain(ex, n, req, mid_change, new_fmt);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [11:0] ex;
        int          n;
        rst = 1'b1; fmt_load = 1'b0; fmt_word = '0; wr_en = 1'b0;
        wr_data = '0; baud_tick = 1'b1; cur_fmt = 5'b00111;
        repeat (3) @(negedge clk);
        check(txd == 1'b1 && hold_empty == 1'b1 && shift_empty == 1'b1, "R2",
              "reset state", {txd, hold_empty, shift_empty}, 3'b111);
        rst = 1'b0;
        @(negedge clk);
        check(txd == 1'b1 && hold_empty == 1'b1 && shift_empty == 1'b1, "R2",
              "idle after reset", {txd, hold_empty, shift_empty}, 3'b111);

        // R1: reset format is 8N1
        send(8'h96, "R1", 1'b0, 5'b0);

        // Vector table: formats (R4, R5) and frame order (R3)
        for (int v = 0; v < 8; v++) begin
            set_fmt(VEC[v][12:8]);
            send(VEC[v][7:0], v[0] ? "R5" : "R4", 1'b0, 5'b0);
        end

        // R1: word presented without load strobe is ignored
        set_fmt(5'b00111);
        @(negedge clk); fmt_word = 5'b11000;
        repeat (4) @(negedge clk);
        send(8'h6B, "R1", 1'b0, 5'b0);

        // R10: format change during a frame affects only the next frame
        set_fmt(5'b11011);
        send(8'hC3, "R10", 1'b1, 5'b00000);
        send(8'hC3, "R10", 1'b0, 5'b0);

        // R9: byte written during a frame waits in the holding buffer
        set_fmt(5'b00111);
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h81;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk);                                  // load edge of first byte
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h7E;
        @(negedge clk); wr_en = 1'b0;
        check(hold_empty == 1'b0 && shift_empty == 1'b0, "R9", "queued during frame",
              {hold_empty, shift_empty}, 2'b00);
        repeat (158) @(negedge clk);
        check(shift_empty == 1'b1 && hold_empty == 1'b0, "R9", "still queued at frame end",
              {shift_empty, hold_empty}, 2'b10);
        @(negedge clk);
        check(shift_empty == 1'b0 && hold_empty == 1'b1 && txd == 1'b0, "R9",
              "queued byte starts", {shift_empty, hold_empty, txd}, 3'b010);
        n = expect_bits(cur_fmt, 8'h7E, ex);
        drain(ex, n, "R9", 1'b0, 5'b0);

        // R7: no baud ticks freezes the frame at the start bit
        set_fmt(5'b00100);                               // 5 data, none, 1 stop
        baud_tick = 1'b0;
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h0A;
        @(negedge clk); wr_en = 1'b0;
        @(negedge clk);
        begin
            bit held;
            held = 1'b1;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (txd != 1'b0 || shift_empty != 1'b0) held = 1'b0;
            end
            check(held, "R7", "frozen without ticks", held, 1);
        end
        baud_tick = 1'b1;
        n = expect_bits(cur_fmt, 8'h0A, ex);             // 7 bits
        repeat (16 * n - 1) @(negedge clk);
        check(shift_empty == 1'b0, "R7", "busy one cycle before end", shift_empty, 0);
        @(negedge clk);
        check(shift_empty == 1'b1 && txd == 1'b1, "R7", "done after 16 ticks per bit",
              {shift_empty, txd}, 2'b11);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule